// File: doc/BRIEF.md
# Corner Splash Overlay with Palette Lookup

This block sits after a raster timing generator and paints a small stored picture into the lower-right corner of the screen. For every pixel coordinate it receives, it decides whether the coordinate lies inside a rectangle whose far edges meet the screen's right and bottom edges. Inside that rectangle it reads an 8-bit colour index from an on-chip picture memory and turns it into a 16-bit RGB565 colour through an on-chip palette. Outside the rectangle, on the visible area, it paints a fill colour equal to the palette colour of the picture's top-left pixel, so the picture blends into a uniform backdrop.

Screen and picture sizes are inputs, so one build serves several display resolutions. Picture indices and palette colours are loaded through a single write port. The overlay works directly on the pixel stream, with no frame memory. It has a fixed delay, and the blanking flag travels with each pixel so the output stays aligned.

Top module: `splash_overlay`

## Requirements
- R1: When a pixel is presented with `in_active` low, the corresponding output pixel (three cycles later) is 16'h0000.
- R2: Every pixel appears on the outputs exactly three clock cycles after it is sampled, and `out_active` equals `in_active` delayed by those three cycles.
- R3: For an active pixel inside the picture rectangle, the output is palette[picture[(x - ox) + (y - oy) * img_w]]. Picture indices are stored row-major. A write with `wr_sel` = 0 stores `wr_data[7:0]` at picture address `wr_addr`.
- R4: For an active pixel outside the picture rectangle, the output is palette[picture[0]]. A write with `wr_sel` = 1 stores `wr_data` (RGB565: red in bits 15:11, green in 10:5, blue in 4:0) at palette entry `wr_addr[7:0]`.
- R5: The picture origin is ox = scr_w - img_w and oy = scr_h - img_h. The rectangle covers ox <= x < ox + img_w and oy <= y < oy + img_h.
- R6: When a picture dimension exceeds the matching screen dimension, that origin is 0, and only the part of the picture that lies on screen (x < scr_w, y < scr_h) is shown. Addressing still uses img_w as the row pitch.
- R7: A write to picture address 0 updates the fill colour to the palette entry named by the new index. The new fill colour applies from the next cycle on.
- R8: A palette write to the entry currently named by picture[0] updates the fill colour to the written value. A palette write to any other entry leaves the fill colour unchanged.
- R9: While reset is held, `out_rgb` is 0 and `out_active` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scr_w | input | CW | Visible screen width in pixels |
| scr_h | input | CW | Visible screen height in lines |
| img_w | input | CW | Picture width in pixels |
| img_h | input | CW | Picture height in lines |
| in_active | input | 1 | Visible-area flag from the timing generator |
| in_x | input | CW | Current pixel column |
| in_y | input | CW | Current line |
| wr_en | input | 1 | Memory write strobe |
| wr_sel | input | 1 | 0 = picture memory, 1 = palette |
| wr_addr | input | AW | Picture address, or palette entry in bits 7:0 |
| wr_data | input | 16 | Picture index in bits 7:0, or RGB565 palette colour |
| out_rgb | output | 16 | RGB565 output pixel |
| out_active | output | 1 | Visible-area flag aligned with out_rgb |

## Verification
Full raster scans with blanking columns and rows on every line separate the blank-forcing path from the colour paths. A small picture anchored in the corner distinguishes the inside lookup from the fill colour, and a tiny 3x2 picture checks the exact origin edges. A picture wider than the screen exercises origin saturation and clipping, where a wrong row pitch or a missing clip shows up as wrong colours. Rewriting picture index 0, then the palette entry it names, then an unrelated palette entry, separates the two fill-refresh triggers from a write that must leave the fill colour alone.

// File: rtl/splash_pkg.sv
// Shared types for the corner splash overlay.
package splash_pkg;
    typedef logic [15:0] rgb565_t;
    localparam int IDX_W = 8;
    localparam int PAL_N = 1 << IDX_W;
    typedef enum logic {
        TGT_PICTURE = 1'b0,
        TGT_PALETTE = 1'b1
    } wr_tgt_e;
endpackage

// File: rtl/splash_geom.sv
// Stage 1 of the overlay: computes the corner-anchored picture origin,
// decides whether the current coordinate hits the picture rectangle and
// forms the row-major picture address.
// Assumes img_w * img_h fits in the picture memory (2**AW entries).
module splash_geom #(
    parameter int CW = 11,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] scr_w,
    input  logic [CW-1:0] scr_h,
    input  logic [CW-1:0] img_w,
    input  logic [CW-1:0] img_h,
    input  logic          in_active,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    output logic [AW-1:0] s1_addr,
    output logic          s1_inside,
    output logic          s1_active
);
    localparam int LW = 2 * CW;

    logic [CW-1:0] org_x, org_y, rel_x, rel_y;
    logic [LW-1:0] lin;
    logic          hit;

    // Origin with saturation at zero, relative position, hit test, address.
    always_comb begin
        org_x = (scr_w > img_w) ? (scr_w - img_w) : '0;
        org_y = (scr_h > img_h) ? (scr_h - img_h) : '0;
        rel_x = in_x - org_x;
        rel_y = in_y - org_y;
        hit   = (in_x >= org_x) && (rel_x < img_w) && (in_x < scr_w) &&
                (in_y >= org_y) && (rel_y < img_h) && (in_y < scr_h);
        lin   = {{CW{1'b0}}, rel_x} + ({{CW{1'b0}}, rel_y} * {{CW{1'b0}}, img_w});
    end

    // Register the stage-1 results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_addr   <= '0;
            s1_inside <= 1'b0;
            s1_active <= 1'b0;
        end else begin
            s1_addr   <= lin[AW-1:0];
            s1_inside <= hit;
            s1_active <= in_active;
        end
    end

    p_origin_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (img_w >= scr_w) |-> (org_x == '0));

    p_hit_on_screen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_inside |-> (($past(in_x) < $past(scr_w)) && ($past(in_y) < $past(scr_h))));
endmodule

// File: rtl/splash_mem.sv
// Picture index memory, RGB565 palette and the fill-colour register.
// Picture read is registered (stage 2), palette read is registered
// (stage 3). The fill colour shadows palette[picture[0]] and is refreshed
// on either write that can change it. Assumes no write while pixels that
// read the written location are in flight.
module splash_mem
    import splash_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [AW-1:0]    wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [IDX_W-1:0] idx_q,
    output rgb565_t          pix_q,
    output rgb565_t          fill_q
);
    localparam int DEPTH = 1 << AW;

    logic [IDX_W-1:0] pic_mem [DEPTH];
    rgb565_t          pal_mem [PAL_N];
    logic [IDX_W-1:0] idx0_q;
    logic             we_pic, we_pal;

    // Decode the write target.
    always_comb begin
        we_pic = wr_en && (wr_tgt_e'(wr_sel) == TGT_PICTURE);
        we_pal = wr_en && (wr_tgt_e'(wr_sel) == TGT_PALETTE);
    end

    // Picture memory: write port and registered read (stage 2).
    always_ff @(posedge clk) begin
        if (we_pic) pic_mem[wr_addr] <= wr_data[IDX_W-1:0];
        idx_q <= pic_mem[rd_addr];
    end

    // Palette: write port and registered lookup of the stage-2 index.
    always_ff @(posedge clk) begin
        if (we_pal) pal_mem[wr_addr[IDX_W-1:0]] <= wr_data;
        pix_q <= pal_mem[idx_q];
    end

    // Fill colour and shadow of picture[0], refreshed by either trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx0_q <= '0;
            fill_q <= '0;
        end else if (we_pic && (wr_addr == '0)) begin
            idx0_q <= wr_data[IDX_W-1:0];
            fill_q <= pal_mem[wr_data[IDX_W-1:0]];
        end else if (we_pal && (wr_addr[IDX_W-1:0] == idx0_q)) begin
            fill_q <= wr_data;
        end
    end

    p_fill_pal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_pal && (wr_addr[IDX_W-1:0] == idx0_q)) |=> (fill_q == $past(wr_data)));

    p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fill_q));
endmodule

// File: rtl/splash_overlay.sv
// Corner splash overlay: three-stage pipeline from (x, y, active) to an
// RGB565 pixel. Stage 1 is the geometry, stage 2 the picture read,
// stage 3 the palette read. The flags travel alongside. Output is zero
// whenever the pixel was presented with active low.
module splash_overlay
    import splash_pkg::*;
#(
    parameter int CW = 11,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] scr_w,
    input  logic [CW-1:0] scr_h,
    input  logic [CW-1:0] img_w,
    input  logic [CW-1:0] img_h,
    input  logic          in_active,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    output logic [15:0]   out_rgb,
    output logic          out_active
);
    logic [AW-1:0]    s1_addr;
    logic             s1_inside, s1_active;
    logic             s2_inside, s2_active, s3_inside, s3_active;
    logic [IDX_W-1:0] idx_q;
    rgb565_t          pix_q, fill_q;
    logic [1:0]       warm_q;

    splash_geom #(.CW(CW), .AW(AW)) u_geom (
        .clk(clk), .rst_n(rst_n),
        .scr_w(scr_w), .scr_h(scr_h), .img_w(img_w), .img_h(img_h),
        .in_active(in_active), .in_x(in_x), .in_y(in_y),
        .s1_addr(s1_addr), .s1_inside(s1_inside), .s1_active(s1_active)
    );

    splash_mem #(.AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(s1_addr), .idx_q(idx_q), .pix_q(pix_q), .fill_q(fill_q)
    );

    // Carry the hit and active flags alongside the two memory reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_inside <= 1'b0;
            s2_active <= 1'b0;
            s3_inside <= 1'b0;
            s3_active <= 1'b0;
        end else begin
            s2_inside <= s1_inside;
            s2_active <= s1_active;
            s3_inside <= s2_inside;
            s3_active <= s2_active;
        end
    end

    // Final selection: blank, picture pixel or fill colour.
    always_comb begin
        out_active = s3_active;
        if (!s3_active)     out_rgb = '0;
        else if (s3_inside) out_rgb = pix_q;
        else                out_rgb = fill_q;
    end

    // Cycles since reset, saturating at 3, for the latency checks.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    p_active_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_active == $past(in_active, 3)));

    p_blank_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && !$past(in_active, 3)) |-> (out_rgb == 16'h0000));
endmodule

// File: tb/splash_overlay_bench.sv
`timescale 1ns/1ps
module splash_overlay_bench;
    localparam int CW = 11;
    localparam int AW = 10;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] scr_w = '0, scr_h = '0, img_w = '0, img_h = '0;
    logic          in_active = 1'b0;
    logic [CW-1:0] in_x = '0, in_y = '0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   out_rgb;
    logic          out_active;

    int n_chk = 0;
    int n_fail = 0;
    int img_m [1024];
    int pal_m [256];
    int    q_rgb[$];
    int    q_de[$];
    string q_tag[$];
    string fill_tag = "R4";
    string in_tag = "R3";
    bit    done = 0;

    always #2 clk = ~clk;

    splash_overlay #(.CW(CW), .AW(AW)) u_splash_overlay (
        .clk(clk), .rst_n(rst_n),
        .scr_w(scr_w), .scr_h(scr_h), .img_w(img_w), .img_h(img_h),
        .in_active(in_active), .in_x(in_x), .in_y(in_y),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_rgb(out_rgb), .out_active(out_active)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference: compute expected pixel and its requirement tag.
    task automatic model(output int exp, output string tag);
        int sw = int'(scr_w), sh = int'(scr_h), iw = int'(img_w), ih = int'(img_h);
        int x = int'(in_x), y = int'(in_y);
        int ox = (sw > iw) ? sw - iw : 0;
        int oy = (sh > ih) ? sh - ih : 0;
        if (!in_active) begin
            exp = 0; tag = "R1";
        end else if (x >= ox && x < ox + iw && x < sw && y >= oy && y < oy + ih && y < sh) begin
            exp = pal_m[img_m[(x - ox) + (y - oy) * iw]]; tag = in_tag;
        end else begin
            exp = pal_m[img_m[0]]; tag = fill_tag;
        end
    endtask

    // One clock: push expectation at the edge, compare three edges later.
    task automatic tick();
        int e; string t;
        @(posedge clk);
        model(e, t);
        q_rgb.push_back(e); q_de.push_back(int'(in_active)); q_tag.push_back(t);
        if (wr_en) begin
            if (wr_sel) pal_m[int'(wr_addr[7:0])] = int'(wr_data);
            else        img_m[int'(wr_addr)] = int'(wr_data[7:0]);
        end
        @(negedge clk);
        if (q_rgb.size() == LAT) begin
            check({q_tag[0], " pixel"}, int'(out_rgb), q_rgb[0]);
            check("R2 active delay", int'(out_active), q_de[0]);
            void'(q_rgb.pop_front()); void'(q_de.pop_front()); void'(q_tag.pop_front());
        end
    endtask

    task automatic write(bit sel, int addr, int data);
        in_active = 1'b0;
        wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(addr); wr_data = 16'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        in_active = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // Full raster with four blank columns and two blank lines.
    task automatic scan();
        for (int y = 0; y < int'(scr_h) + 2; y++) begin
            for (int x = 0; x < int'(scr_w) + 4; x++) begin
                in_x = CW'(x); in_y = CW'(y);
                in_active = (x < int'(scr_w)) && (y < int'(scr_h));
                tick();
            end
        end
        idle(LAT + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        // R9: reset state with active pixels applied
        in_active = 1'b1; scr_w = 11'd16; scr_h = 11'd12;
        repeat (4) @(negedge clk);
        check("R9 reset rgb", int'(out_rgb), 0);
        check("R9 reset active", int'(out_active), 0);
        rst_n = 1'b1;
        in_active = 1'b0;
        idle(LAT + 1);

        // Load palette then picture (20 used entries for 5x4).
        for (int j = 0; j < 256; j++) write(1'b1, j, (j * 40503 + 11) & 16'hFFFF);
        for (int i = 0; i < 60; i++) write(1'b0, i, (i * 37 + 5) & 8'hFF);
        idle(LAT + 1);

        // R3/R4/R5: 5x4 picture in a 16x12 screen, origin (11,8)
        img_w = 11'd5; img_h = 11'd4; in_tag = "R3"; fill_tag = "R4";
        scan();

        // R5: 3x2 picture, origin (13,10)
        img_w = 11'd3; img_h = 11'd2; in_tag = "R5"; fill_tag = "R5";
        scan();

        // R6: picture wider than screen, origin x saturates at 0
        img_w = 11'd20; img_h = 11'd3; in_tag = "R6"; fill_tag = "R6";
        scan();

        // R7: new index at picture address 0 changes the fill colour
        img_w = 11'd5; img_h = 11'd4;
        write(1'b0, 0, 200);
        idle(LAT + 1);
        in_tag = "R7"; fill_tag = "R7";
        scan();

        // R8: palette write to the named entry, then to an unrelated one
        write(1'b1, 200, 16'hBEEF);
        idle(LAT + 1);
        in_tag = "R8"; fill_tag = "R8";
        scan();
        write(1'b1, 7, 16'h1357);
        idle(LAT + 1);
        scan();

        finish_up();
    end
endmodule